// File: doc/BRIEF.md
# Serial Queue Status and Halt Logic

This block keeps the status of a queued serial master. It holds three pieces of state. The first is a mode-fault flag, which records that another node pulled the slave-select pin low while this node acted as master. The second is a halt-acknowledge flag. The third is a pointer to the last command that the queue completed. It also raises an interrupt request when the engine is halted and that interrupt is enabled.

A halt has two sources: a software halt request, and a global freeze signal that only counts when its enable bit is set. The engine stops only between commands. A command in flight therefore finishes before the acknowledge appears. The completed-command pointer changes only when a command finishes. It keeps its value when a new queue starts, so software can see how far the previous queue got.

Both flags are sticky. Software clears a flag in two steps: it reads the status while the flag is one, then writes zero to that flag's bit. The command sequencer and the shift engine sit outside this block. They report through `cmd_active`, `cmd_done` and `cmd_idx`.

Top module: `sq_status_top`

## Requirements
- R1: After reset, `mode_fault`, `halt_ack` and `halt_irq` are 0 and `done_ptr` is 0.
- R2: The slave-select pin `ss_in_n` passes through a synchronizer of `SYNC_STAGES` flops. With `master_en` high and the pin low, `mode_fault` rises on the third rising edge after the pin falls (default of 2 stages), and not before. With `master_en` low, a low pin never sets it.
- R3: The halt condition is `halt_req` high, or `frz_in` and `frz_en` both high. A cycle is a command boundary when `cmd_active` is low or `cmd_done` is high. `halt_ack` becomes 1 on the rising edge that ends a boundary cycle in which the halt condition holds.
- R4: While `cmd_active` is high and `cmd_done` is low, `halt_ack` does not become 1, whatever the halt condition.
- R5: `frz_in` high with `frz_en` low has no effect on `halt_ack`.
- R6: `halt_irq` is 1 exactly one cycle after a cycle in which both `halt_irq_en` and `halt_ack` are 1. Otherwise it is 0.
- R7: `done_ptr` (5 bits by default) takes the value of `cmd_idx` on the edge that ends a cycle with `cmd_done` high. At all other times it holds, including across the start of a new queue.
- R8: Once set, `mode_fault` and `halt_ack` stay 1 after their set conditions go away. Only the clear sequence of R9 lowers them.
- R9: Clearing a flag takes two steps.
  - A `stat_rd` pulse arms each flag that is 1 at that moment.
  - A `stat_wr` pulse then clears an armed flag whose data bit is 0. Bit 0 of `stat_wdata` is mode fault and bit 1 is halt acknowledge.
  - A write of 1, or a write to a flag that is not armed, leaves the flag unchanged.
  - Every write disarms the flags.
- R10: When a flag's set condition holds in the same cycle as a valid clear, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| master_en | input | 1 | Node is configured as bus master |
| ss_in_n | input | 1 | Slave-select pin, asynchronous, active low |
| halt_req | input | 1 | Software halt request |
| frz_in | input | 1 | Global freeze signal |
| frz_en | input | 1 | Lets `frz_in` halt the engine |
| halt_irq_en | input | 1 | Halt interrupt enable |
| cmd_active | input | 1 | A queued command is in progress |
| cmd_done | input | 1 | Pulse: the current command has finished |
| cmd_idx | input | PTR_W | Index of the command that is finishing |
| stat_rd | input | 1 | Pulse: software reads the status |
| stat_wr | input | 1 | Pulse: software writes the status |
| stat_wdata | input | 2 | Write data: bit 0 mode fault, bit 1 halt ack |
| mode_fault | output | 1 | Sticky mode-fault flag |
| halt_ack | output | 1 | Sticky halt-acknowledge flag |
| halt_irq | output | 1 | Halt interrupt request |
| done_ptr | output | PTR_W | Last completed command index |

## Verification
The bench uses the default parameters: `PTR_W` = 5 and `SYNC_STAGES` = 2. With a 5-bit pointer, the extreme indices 0 and 31 can both be loaded and held. With two synchronizer stages, the exact three-edge latency of a mode fault can be checked on both sides of the edge where it rises. These values also make it practical to wait through a long in-flight command, to hit a set and a clear in the same cycle, and to drive the freeze path with its enable both off and on.

// File: rtl/sqs_pkg.sv
package sqs_pkg;

    // Bit positions of the two flags in the status write data.
    localparam int unsigned MODF_BIT  = 0;
    localparam int unsigned HALTA_BIT = 1;
    localparam int unsigned STAT_W    = 2;

    // State of one sticky flag together with its read-arm bit.
    typedef struct packed {
        logic flag;
        logic armed;
    } sticky_t;

    // Registered state kept at the top level.
    typedef struct packed {
        logic irq;
    } top_state_t;

endpackage

// File: rtl/sqs_sync.sv
module sqs_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = chain_q;
                chain_d[0] = async_i;
                for (int i = 1; i < int'(STAGES); i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= chain_d;
            end

            assign sync_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sqs_sticky.sv
module sqs_sticky
    import sqs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_val_i,
    output logic flag_o
);

    sticky_t st_d, st_q;
    logic    clr_ok;

    always_comb begin
        st_d   = st_q;
        clr_ok = wr_i && !wr_val_i && st_q.armed;

        // Arm on a read that sees the flag high; any write disarms.
        if (wr_i)                  st_d.armed = 1'b0;
        else if (rd_i && st_q.flag) st_d.armed = 1'b1;

        // Setting outranks clearing.
        if (set_i)       st_d.flag = 1'b1;
        else if (clr_ok) st_d.flag = 1'b0;

        if (!st_d.flag) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/sqs_ptr.sv
module sqs_ptr #(
    parameter int unsigned PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PTR_W-1:0] idx_i,
    output logic [PTR_W-1:0] ptr_o
);

    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) ptr_d = idx_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/sq_status_top.sv
module sq_status_top
    import sqs_pkg::*;
#(
    parameter int unsigned PTR_W       = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              ss_in_n,
    input  logic              halt_req,
    input  logic              frz_in,
    input  logic              frz_en,
    input  logic              halt_irq_en,
    input  logic              cmd_active,
    input  logic              cmd_done,
    input  logic [PTR_W-1:0]  cmd_idx,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic              mode_fault,
    output logic              halt_ack,
    output logic              halt_irq,
    output logic [PTR_W-1:0]  done_ptr
);

    localparam int unsigned NFLAG = STAT_W;

    logic             ss_sync_n;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_q;
    logic             halt_cond;
    logic             at_boundary;
    top_state_t       st_d, st_q;

    sqs_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_ss_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ss_in_n),
        .sync_o  (ss_sync_n)
    );

    always_comb begin
        halt_cond   = halt_req || (frz_in && frz_en);
        at_boundary = !cmd_active || cmd_done;
        flag_set            = '0;
        flag_set[MODF_BIT]  = master_en && !ss_sync_n;
        flag_set[HALTA_BIT] = halt_cond && at_boundary;
    end

    generate
        for (genvar g = 0; g < int'(NFLAG); g++) begin : g_flag
            sqs_sticky u_flag (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (flag_set[g]),
                .rd_i     (stat_rd),
                .wr_i     (stat_wr),
                .wr_val_i (stat_wdata[g]),
                .flag_o   (flag_q[g])
            );
        end
    endgenerate

    sqs_ptr #(
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cmd_done),
        .idx_i  (cmd_idx),
        .ptr_o  (done_ptr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = halt_irq_en && flag_q[HALTA_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_fault = flag_q[MODF_BIT];
    assign halt_ack   = flag_q[HALTA_BIT];
    assign halt_irq   = st_q.irq;

endmodule

// File: rtl/sqs_checker.sv
module sqs_checker #(
    parameter int unsigned PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             master_en,
    input logic             ss_sync_n,
    input logic             halt_req,
    input logic             frz_in,
    input logic             frz_en,
    input logic             halt_irq_en,
    input logic             cmd_active,
    input logic             cmd_done,
    input logic [PTR_W-1:0] cmd_idx,
    input logic             stat_wr,
    input logic             mode_fault,
    input logic             halt_ack,
    input logic             halt_irq,
    input logic [PTR_W-1:0] done_ptr
);

    // R2 and R10: the fault condition always leaves the flag set.
    a_r2_modf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && !ss_sync_n) |=> mode_fault);

    // R3: a halt condition at a command boundary leaves the acknowledge set.
    a_r3_halt_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ((halt_req || (frz_in && frz_en)) && (!cmd_active || cmd_done)) |=> halt_ack);

    // R4: the acknowledge never appears in the middle of a command.
    a_r4_no_midcmd_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_active && !cmd_done && !halt_ack) |=> !halt_ack);

    // R6: the interrupt follows an enabled acknowledge by one cycle.
    a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        halt_irq |-> $past(halt_irq_en && halt_ack));

    a_r6_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_irq_en && halt_ack) |=> halt_irq);

    // R7: the pointer loads on completion and holds otherwise.
    a_r7_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> (done_ptr == $past(cmd_idx)));

    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |=> $stable(done_ptr));

    // R8: without a write, neither flag can fall.
    a_r8_modf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fault && !stat_wr) |=> mode_fault);

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_ack && !stat_wr) |=> halt_ack);

endmodule

bind sq_status_top sqs_checker #(
    .PTR_W (PTR_W)
) u_sqs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en   (master_en),
    .ss_sync_n   (ss_sync_n),
    .halt_req    (halt_req),
    .frz_in      (frz_in),
    .frz_en      (frz_en),
    .halt_irq_en (halt_irq_en),
    .cmd_active  (cmd_active),
    .cmd_done    (cmd_done),
    .cmd_idx     (cmd_idx),
    .stat_wr     (stat_wr),
    .mode_fault  (mode_fault),
    .halt_ack    (halt_ack),
    .halt_irq    (halt_irq),
    .done_ptr    (done_ptr)
);

// File: tb/test_sq_status_top.sv
module test_sq_status_top;

    localparam int unsigned PTR_W = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             master_en, ss_in_n, halt_req, frz_in, frz_en, halt_irq_en;
    logic             cmd_active, cmd_done;
    logic [PTR_W-1:0] cmd_idx;
    logic             stat_rd, stat_wr;
    logic [1:0]       stat_wdata;
    logic             mode_fault, halt_ack, halt_irq;
    logic [PTR_W-1:0] done_ptr;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sq_status_top #(
        .PTR_W       (PTR_W),
        .SYNC_STAGES (2)
    ) i_sq_status_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_en   (master_en),
        .ss_in_n     (ss_in_n),
        .halt_req    (halt_req),
        .frz_in      (frz_in),
        .frz_en      (frz_en),
        .halt_irq_en (halt_irq_en),
        .cmd_active  (cmd_active),
        .cmd_done    (cmd_done),
        .cmd_idx     (cmd_idx),
        .stat_rd     (stat_rd),
        .stat_wr     (stat_wr),
        .stat_wdata  (stat_wdata),
        .mode_fault  (mode_fault),
        .halt_ack    (halt_ack),
        .halt_irq    (halt_irq),
        .done_ptr    (done_ptr)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Read, then write the given data: one cycle each.
    task automatic rd_then_wr(input logic [1:0] data);
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
        stat_wr = 1'b1; stat_wdata = data; step(1);
        stat_wr = 1'b0; stat_wdata = 2'b11;
    endtask

    task automatic t_reset;
        check("R1 mode_fault", mode_fault, 0);
        check("R1 halt_ack", halt_ack, 0);
        check("R1 halt_irq", halt_irq, 0);
        check("R1 done_ptr", done_ptr, 0);
    endtask

    task automatic t_mode_fault;
        master_en = 1'b0; ss_in_n = 1'b0; step(4);
        check("R2 no fault as slave", mode_fault, 0);
        ss_in_n = 1'b1; step(3);
        master_en = 1'b1; ss_in_n = 1'b0; step(2);
        check("R2 not before third edge", mode_fault, 0);
        step(1);
        check("R2 set on third edge", mode_fault, 1);
        ss_in_n = 1'b1; step(4);
        check("R8 fault sticky", mode_fault, 1);
    endtask

    task automatic t_clear;
        stat_wr = 1'b1; stat_wdata = 2'b00; step(1); stat_wr = 1'b0;
        check("R9 unarmed write keeps flag", mode_fault, 1);
        rd_then_wr(2'b01);
        check("R9 write of one keeps flag", mode_fault, 1);
        stat_wr = 1'b1; stat_wdata = 2'b00; step(1); stat_wr = 1'b0;
        check("R9 write disarms", mode_fault, 1);
        rd_then_wr(2'b10);
        check("R9 read then zero clears", mode_fault, 0);
        ss_in_n = 1'b0; step(3);
        check("R2 fault set again", mode_fault, 1);
        rd_then_wr(2'b00);
        check("R10 set beats clear", mode_fault, 1);
        ss_in_n = 1'b1; step(3);
        rd_then_wr(2'b00);
        check("R9 clear after condition gone", mode_fault, 0);
        master_en = 1'b0;
    endtask

    task automatic t_halt_idle;
        halt_irq_en = 1'b1; cmd_active = 1'b0; halt_req = 1'b1; step(1);
        check("R3 idle halt ack", halt_ack, 1);
        check("R6 irq one cycle later", halt_irq, 0);
        step(1);
        check("R6 irq raised", halt_irq, 1);
        halt_req = 1'b0; halt_irq_en = 1'b0; step(1);
        check("R6 irq drops with enable", halt_irq, 0);
        check("R8 halt ack sticky", halt_ack, 1);
        rd_then_wr(2'b00);
        check("R9 halt ack cleared", halt_ack, 0);
    endtask

    task automatic t_halt_busy;
        cmd_active = 1'b1; halt_req = 1'b1; cmd_idx = 5'd7; step(5);
        check("R4 no ack mid command", halt_ack, 0);
        cmd_done = 1'b1; step(1);
        cmd_done = 1'b0; cmd_active = 1'b0;
        check("R3 ack after command end", halt_ack, 1);
        check("R7 ptr loaded", done_ptr, 7);
        halt_req = 1'b0; rd_then_wr(2'b00);
        check("R9 halt ack cleared", halt_ack, 0);
    endtask

    task automatic t_freeze;
        frz_in = 1'b1; frz_en = 1'b0; step(3);
        check("R5 freeze ignored", halt_ack, 0);
        frz_en = 1'b1; step(1);
        check("R3 gated freeze acks", halt_ack, 1);
        frz_in = 1'b0; frz_en = 1'b0; rd_then_wr(2'b00);
        check("R9 cleared after freeze", halt_ack, 0);
    endtask

    task automatic t_pointer;
        cmd_active = 1'b1; cmd_idx = 5'd31; cmd_done = 1'b1; step(1); cmd_done = 1'b0;
        check("R7 ptr max index", done_ptr, 31);
        cmd_idx = 5'd0; step(4);
        check("R7 ptr holds into new queue", done_ptr, 31);
        cmd_done = 1'b1; step(1); cmd_done = 1'b0;
        check("R7 ptr zero index", done_ptr, 0);
        cmd_idx = 5'd18; cmd_done = 1'b1; step(1); cmd_done = 1'b0;
        cmd_idx = 5'd5; step(2);
        check("R7 ptr ignores idx without done", done_ptr, 18);
        cmd_active = 1'b0;
    endtask

    task automatic t_irq_off;
        halt_irq_en = 1'b0; halt_req = 1'b1; step(1);
        check("R3 ack with irq off", halt_ack, 1);
        step(2);
        check("R6 no irq when disabled", halt_irq, 0);
        halt_req = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; master_en = 1'b0; ss_in_n = 1'b1; halt_req = 1'b0;
        frz_in = 1'b0; frz_en = 1'b0; halt_irq_en = 1'b0; cmd_active = 1'b0;
        cmd_done = 1'b0; cmd_idx = '0; stat_rd = 1'b0; stat_wr = 1'b0;
        stat_wdata = 2'b11;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_mode_fault();
        t_clear();
        t_halt_idle();
        t_halt_busy();
        t_freeze();
        t_pointer();
        t_irq_off();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule